// File: doc/BRIEF.md
# Paged MDIO Switch-Register Bridge

This block lets a host reach a 32-bit switch register space through a management port that only moves 16 bits per transaction. The host presents one command at a time: a word read, a word write, a masked read-modify-write, or a poll that rereads a word until a masked compare succeeds. Each command carries an 18-bit byte address, a 32-bit data word (write value, set bits or expected value), a 32-bit mask and a retry count. The block answers with one completion pulse, a result word and an error flag.

Downstream, the block drives a request/acknowledge port into an existing clause-22 MDIO master. It supplies the PHY address, the register number, the write data and the direction. The upper address bits select a page. The block remembers the last page it wrote. It writes the page register only when the page changes, and it then waits a settle time before touching any data register. Every 32-bit access is split into two ordered 16-bit halves.

Top module: `mdio_page_bridge`

## Requirements
- R1: Byte addresses are word aligned (bits 1:0 zero). Bits 17:9 give the page, bits 8:6 give a sub-PHY index and bits 5:1 give the register. Data transactions use PHY address 0x10 OR the sub-PHY index.
- R2: When no page is cached, or the page differs from the cached one, the first transaction of the command writes the page value, zero-extended, to PHY 0x18 register 0. Reset clears the cache, so the first command after reset always writes the page.
- R3: After a page write is acknowledged, no new request is raised for SETTLE_CYC cycles.
- R4: On a page hit, the command issues no page write and inserts no settle wait.
- R5: A read (cmd_op 0) reads register r and then r+1, and returns {second half, first half}.
- R6: A write (cmd_op 1) with cfg_lo_first=1 writes data[15:0] to r and then data[31:16] to r+1. With cfg_lo_first=0 it writes r+1 first and r second. rsp_data returns the value written.
- R7: A read-modify-write (cmd_op 2) reads the word, writes back (word & ~mask) | data in the R6 order, and returns that value.
- R8: A poll (cmd_op 3) rereads the word until (word & mask) == data. It makes at most retries+1 attempts, leaves at least GAP_CYC idle cycles between attempts, and on a match returns the word with rsp_err=0.
- R9: When the retries run out without a match, the poll completes with rsp_err=1 and returns the last word read. No other command sets rsp_err.
- R10: Each accepted command produces exactly one single-cycle rsp_done. cmd_ready is high only while idle, and a cmd_valid pulse while cmd_ready is low is ignored.
- R11: While mdio_req is high and mdio_ack is low, mdio_phy, mdio_reg, mdio_wdata and mdio_write do not change.
- R12: After reset, cmd_ready=1, mdio_req=0 and rsp_done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lo_first | input | 1 | Write order select: 1 = low half first |
| cmd_valid | input | 1 | Command strobe, taken when cmd_ready is high |
| cmd_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 poll |
| cmd_addr | input | 18 | Byte address in switch space |
| cmd_wdata | input | 32 | Write value, set bits, or poll expected value |
| cmd_mask | input | 32 | Clear mask (RMW) or compare mask (poll) |
| cmd_retries | input | 8 | Extra poll attempts after the first |
| cmd_ready | output | 1 | Idle, able to take a command |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Poll gave up, valid with rsp_done |
| rsp_data | output | 32 | Result word, valid with rsp_done |
| mdio_req | output | 1 | Transaction request to the MDIO master |
| mdio_ack | input | 1 | One-cycle completion from the MDIO master |
| mdio_phy | output | 5 | PHY address of the transaction |
| mdio_reg | output | 5 | Register number of the transaction |
| mdio_wdata | output | 16 | Write data |
| mdio_write | output | 1 | 1 write, 0 read |
| mdio_rdata | input | 16 | Read data, valid with mdio_ack |

## Verification
The hardest state to reach from the ports is a command arriving while a long poll is still running, together with a poll that succeeds only after a few misses. The bench's MDIO responder returns a status value that turns true only after a set number of reads. A second process pulses a write command partway through a poll that never matches. A later read of the target word shows whether that write leaked through. The responder also times every request, which exposes the settle and retry gaps, and it flags any field that moves before its acknowledge.

// File: rtl/mpb_pkg.sv
// Shared types and constants of the paged MDIO bridge.
// Assumes clause-22 framing: 5-bit PHY and register numbers, 16-bit data.
package mpb_pkg;

    localparam int PAGE_W = 9;
    localparam int SUB_W  = 3;
    localparam int REG_W  = 5;
    localparam int ADDR_W = PAGE_W + SUB_W + REG_W + 1;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int PHY_W  = 5;

    localparam logic [PHY_W-1:0] PAGE_SEL_PHY  = 5'h18;
    localparam logic [REG_W-1:0] PAGE_SEL_REG  = 5'd0;
    localparam logic [PHY_W-1:0] DATA_PHY_BASE = 5'h10;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2,
        OP_POLL  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PAGE,
        S_SETTLE,
        S_RD_LO,
        S_RD_HI,
        S_EVAL,
        S_WR_A,
        S_WR_B,
        S_GAP,
        S_DONE
    } state_e;

    // First data state of a command once its page is in place.
    function automatic state_e first_data_state(op_e op);
        return (op == OP_WRITE) ? S_WR_A : S_RD_LO;
    endfunction

endpackage

// File: rtl/mpb_addr_split.sv
// Splits a switch byte address into page, data PHY and register pair.
// Assumes word-aligned addresses; bit 0 carries no meaning here.
module mpb_addr_split
    import mpb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [PAGE_W-1:0] page,
    output logic [PHY_W-1:0]  data_phy,
    output logic [REG_W-1:0]  reg_lo,
    output logic [REG_W-1:0]  reg_hi
);
    localparam int REG_LSB  = 1;
    localparam int SUB_LSB  = REG_LSB + REG_W;
    localparam int PAGE_LSB = SUB_LSB + SUB_W;

    // Field extraction and PHY/register derivation.
    always_comb begin
        page     = addr[PAGE_LSB +: PAGE_W];
        data_phy = DATA_PHY_BASE | PHY_W'(addr[SUB_LSB +: SUB_W]);
        reg_lo   = addr[REG_LSB +: REG_W];
        reg_hi   = addr[REG_LSB +: REG_W] + REG_W'(1);
    end
endmodule

// File: rtl/mpb_page_cache.sv
// Holds the page value last written to the page-select register.
// Assumes load is raised only when that write has been acknowledged.
module mpb_page_cache #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] probe_page,
    output logic          hit,
    input  logic          load,
    input  logic [PW-1:0] load_page
);
    logic          valid_q;
    logic [PW-1:0] page_q;

    // Store the page on load; reset marks the cache empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            page_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            page_q  <= load_page;
        end
    end

    // Hit only when a page is held and it equals the probe.
    assign hit = valid_q && (page_q == probe_page);
endmodule

// File: rtl/mpb_wait_timer.sv
// Down-counter for settle and retry gaps: start with length N gives
// zero asserted again after N cycles. Assumes N >= 1.
module mpb_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    // Load len-1 on start, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= len - CW'(1);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/mdio_page_bridge.sv
// Bridges 32-bit switch register commands onto 16-bit MDIO transactions.
// Writes the page register on a page change and waits SETTLE_CYC cycles,
// then moves the word as two ordered halves. Supports read, write,
// read-modify-write and masked polling with GAP_CYC between attempts.
// Assumes one outstanding MDIO transaction and a one-cycle mdio_ack.
module mdio_page_bridge
    import mpb_pkg::*;
#(
    parameter int SETTLE_CYC = 200000,
    parameter int GAP_CYC    = 100,
    parameter int RETRY_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_lo_first,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [WORD_W-1:0]    cmd_wdata,
    input  logic [WORD_W-1:0]    cmd_mask,
    input  logic [RETRY_W-1:0]   cmd_retries,
    output logic                 cmd_ready,
    output logic                 rsp_done,
    output logic                 rsp_err,
    output logic [WORD_W-1:0]    rsp_data,
    output logic                 mdio_req,
    input  logic                 mdio_ack,
    output logic [PHY_W-1:0]     mdio_phy,
    output logic [REG_W-1:0]     mdio_reg,
    output logic [HALF_W-1:0]    mdio_wdata,
    output logic                 mdio_write,
    input  logic [HALF_W-1:0]    mdio_rdata
);
    localparam int MAX_WAIT = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int SINCE_W  = $clog2(SETTLE_CYC + 1);

    state_e                state_q;
    op_e                   op_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [WORD_W-1:0]     data_q, mask_q, wval_q, rsp_data_q;
    logic [RETRY_W-1:0]    tries_q;
    logic                  lofirst_q, rsp_err_q;
    logic [HALF_W-1:0]     lo_q, hi_q;

    logic [ADDR_W-1:0]     addr_sel;
    logic [PAGE_W-1:0]     page;
    logic [PHY_W-1:0]      data_phy;
    logic [REG_W-1:0]      reg_lo, reg_hi;
    logic                  pg_hit, pg_load;
    logic                  tmr_start, tmr_zero;
    logic [CNT_W-1:0]      tmr_len;
    logic [WORD_W-1:0]     word;
    logic                  poll_match, poll_retry;

    // Decode the incoming address while idle, the held one afterwards.
    assign addr_sel = (state_q == S_IDLE) ? cmd_addr : addr_q;

    mpb_addr_split u_split (
        .addr     (addr_sel),
        .page     (page),
        .data_phy (data_phy),
        .reg_lo   (reg_lo),
        .reg_hi   (reg_hi)
    );

    assign pg_load = (state_q == S_PAGE) && mdio_ack;

    mpb_page_cache #(.PW(PAGE_W)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_page (page),
        .hit        (pg_hit),
        .load       (pg_load),
        .load_page  (page)
    );

    // Word assembled from the two read halves and the poll decision.
    assign word       = {hi_q, lo_q};
    assign poll_match = ((word & mask_q) == data_q);
    assign poll_retry = (state_q == S_EVAL) && (op_q == OP_POLL) &&
                        !poll_match && (tries_q != '0);

    // Start the shared timer on entry to the settle or retry gap.
    always_comb begin
        tmr_start = pg_load || poll_retry;
        tmr_len   = pg_load ? CNT_W'(SETTLE_CYC) : CNT_W'(GAP_CYC);
    end

    mpb_wait_timer #(.CW(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (tmr_len),
        .zero  (tmr_zero)
    );

    // Command sequencer: page handling, half accesses, evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= OP_READ;
            addr_q     <= '0;
            data_q     <= '0;
            mask_q     <= '0;
            wval_q     <= '0;
            tries_q    <= '0;
            lofirst_q  <= 1'b1;
            lo_q       <= '0;
            hi_q       <= '0;
            rsp_data_q <= '0;
            rsp_err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (cmd_valid) begin
                    op_q      <= op_e'(cmd_op);
                    addr_q    <= cmd_addr;
                    data_q    <= cmd_wdata;
                    mask_q    <= cmd_mask;
                    wval_q    <= cmd_wdata;
                    tries_q   <= cmd_retries;
                    lofirst_q <= cfg_lo_first;
                    state_q   <= pg_hit ? first_data_state(op_e'(cmd_op)) : S_PAGE;
                end
                S_PAGE:   if (mdio_ack) state_q <= S_SETTLE;
                S_SETTLE: if (tmr_zero) state_q <= first_data_state(op_q);
                S_RD_LO: if (mdio_ack) begin
                    lo_q    <= mdio_rdata;
                    state_q <= S_RD_HI;
                end
                S_RD_HI: if (mdio_ack) begin
                    hi_q    <= mdio_rdata;
                    state_q <= S_EVAL;
                end
                S_EVAL: begin
                    if (op_q == OP_RMW) begin
                        wval_q  <= (word & ~mask_q) | data_q;
                        state_q <= S_WR_A;
                    end else if (op_q == OP_POLL && !poll_match) begin
                        if (tries_q == '0) begin
                            rsp_data_q <= word;
                            rsp_err_q  <= 1'b1;
                            state_q    <= S_DONE;
                        end else begin
                            tries_q <= tries_q - RETRY_W'(1);
                            state_q <= S_GAP;
                        end
                    end else begin
                        rsp_data_q <= word;
                        rsp_err_q  <= 1'b0;
                        state_q    <= S_DONE;
                    end
                end
                S_WR_A: if (mdio_ack) state_q <= S_WR_B;
                S_WR_B: if (mdio_ack) begin
                    rsp_data_q <= wval_q;
                    rsp_err_q  <= 1'b0;
                    state_q    <= S_DONE;
                end
                S_GAP:  if (tmr_zero) state_q <= S_RD_LO;
                S_DONE: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Downstream fields derived from the state and the held command only.
    always_comb begin
        mdio_req   = 1'b0;
        mdio_phy   = '0;
        mdio_reg   = '0;
        mdio_wdata = '0;
        mdio_write = 1'b0;
        unique case (state_q)
            S_PAGE: begin
                mdio_req   = 1'b1;
                mdio_phy   = PAGE_SEL_PHY;
                mdio_reg   = PAGE_SEL_REG;
                mdio_wdata = {{(HALF_W-PAGE_W){1'b0}}, page};
                mdio_write = 1'b1;
            end
            S_RD_LO: begin
                mdio_req = 1'b1;
                mdio_phy = data_phy;
                mdio_reg = reg_lo;
            end
            S_RD_HI: begin
                mdio_req = 1'b1;
                mdio_phy = data_phy;
                mdio_reg = reg_hi;
            end
            S_WR_A: begin
                mdio_req   = 1'b1;
                mdio_phy   = data_phy;
                mdio_write = 1'b1;
                mdio_reg   = lofirst_q ? reg_lo : reg_hi;
                mdio_wdata = lofirst_q ? wval_q[HALF_W-1:0] : wval_q[WORD_W-1:HALF_W];
            end
            S_WR_B: begin
                mdio_req   = 1'b1;
                mdio_phy   = data_phy;
                mdio_write = 1'b1;
                mdio_reg   = lofirst_q ? reg_hi : reg_lo;
                mdio_wdata = lofirst_q ? wval_q[WORD_W-1:HALF_W] : wval_q[HALF_W-1:0];
            end
            default: ;
        endcase
    end

    // Host-side status outputs.
    assign cmd_ready = (state_q == S_IDLE);
    assign rsp_done  = (state_q == S_DONE);
    assign rsp_err   = rsp_err_q;
    assign rsp_data  = rsp_data_q;

    // Assertion aid: cycles since the last page-select acknowledge.
    logic               pg_seen_q;
    logic [SINCE_W-1:0] since_pg_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_seen_q  <= 1'b0;
            since_pg_q <= '0;
        end else if (pg_load) begin
            pg_seen_q  <= 1'b1;
            since_pg_q <= '0;
        end else if (since_pg_q != SINCE_W'(SETTLE_CYC)) begin
            since_pg_q <= since_pg_q + SINCE_W'(1);
        end
    end

    // R1: commands carry word-aligned addresses.
    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |-> cmd_addr[1:0] == 2'b00);

    // R1: every non-page transaction addresses the data PHY range.
    a_r1_data_phy: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req && mdio_phy != PAGE_SEL_PHY |-> mdio_phy[4:3] == 2'b10);

    // R2: the page PHY is only ever written, and only at register 0.
    a_r2_page_reg: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req && mdio_phy == PAGE_SEL_PHY |-> mdio_write && mdio_reg == PAGE_SEL_REG);

    // R3: no request inside the settle window after a page write.
    a_r3_settle: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req && pg_seen_q |-> since_pg_q == SINCE_W'(SETTLE_CYC));

    // R9: only a poll may finish with the error flag.
    a_r9_err_poll: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && rsp_err |-> op_q == OP_POLL);

    // R10: completion is a single cycle and never while idle.
    a_r10_one_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done && cmd_ready);

    // R11: request fields hold until acknowledged.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req && !mdio_ack |=> mdio_req &&
            $stable({mdio_phy, mdio_reg, mdio_wdata, mdio_write}));
endmodule

// File: tb/test_mdio_page_bridge.sv
// Self-checking bench: vector table walk, then directed corner tests.
module test_mdio_page_bridge;
    localparam int SETTLE = 12;
    localparam int GAP    = 4;
    localparam int LAT    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_lo_first = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [17:0] cmd_addr = '0;
    logic [31:0] cmd_wdata = '0, cmd_mask = '0;
    logic [7:0]  cmd_retries = '0;
    logic        cmd_ready, rsp_done, rsp_err;
    logic [31:0] rsp_data;
    logic        mdio_req, mdio_write;
    logic        mdio_ack = 1'b0;
    logic [4:0]  mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata;
    logic [15:0] mdio_rdata = '0;

    mdio_page_bridge #(.SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .RETRY_W(8)) i_mdio_page_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_lo_first(cfg_lo_first),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask), .cmd_retries(cmd_retries),
        .cmd_ready(cmd_ready), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_data(rsp_data), .mdio_req(mdio_req), .mdio_ack(mdio_ack),
        .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
        .mdio_write(mdio_write), .mdio_rdata(mdio_rdata)
    );

    always #5ns clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0;

    // Device model state: page register, word halves, transaction log.
    logic [8:0]  dev_page = '0;
    logic [15:0] dev_mem [int];
    int          poll_key, poll_reads = 0, poll_need = 0;
    int          stab_err = 0;
    int          log_n = 0;
    logic [4:0]  log_phy [64];
    logic [4:0]  log_reg [64];
    logic [15:0] log_wd  [64];
    logic        log_wr  [64];
    int          log_t   [64];

    function automatic int key_of(logic [8:0] pg, logic [4:0] phy, logic [4:0] rg);
        return int'({pg, phy[2:0], rg});
    endfunction

    // MDIO master model: LAT cycles of latency, one-cycle acknowledge.
    initial begin
        poll_key = key_of(9'd7, 5'h11, 5'd2);
        forever begin
            @(negedge clk);
            mdio_ack = 1'b0;
            if (mdio_req) begin
                automatic logic [4:0]  p = mdio_phy;
                automatic logic [4:0]  r = mdio_reg;
                automatic logic [15:0] w = mdio_wdata;
                automatic logic        wr = mdio_write;
                automatic int          t = cyc;
                automatic int          k;
                repeat (LAT) begin
                    @(negedge clk);
                    if (mdio_phy !== p || mdio_reg !== r || mdio_wdata !== w ||
                        mdio_write !== wr) stab_err++;
                end
                k = key_of(dev_page, p, r);
                if (wr) begin
                    if (p == 5'h18 && r == 5'd0) dev_page = w[8:0];
                    else if (p[4:3] == 2'b10)   dev_mem[k] = w;
                end else if (k == poll_key) begin
                    poll_reads++;
                    mdio_rdata = (poll_reads >= poll_need) ? 16'h0001 : 16'h0000;
                end else begin
                    mdio_rdata = dev_mem.exists(k) ? dev_mem[k] : 16'h0000;
                end
                if (log_n < 64) begin
                    log_phy[log_n] = p; log_reg[log_n] = r; log_wd[log_n] = w;
                    log_wr[log_n] = wr; log_t[log_n] = t;
                end
                log_n++;
                mdio_ack = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    // Issue one command, wait for completion, count completion pulses.
    task automatic run_cmd(input logic [1:0] op, input logic [17:0] a,
                           input logic [31:0] d, input logic [31:0] m,
                           input logic [7:0] tr, output logic [31:0] got,
                           output logic got_err, output int dones);
        int guard = 0;
        dones = 0; got = '0; got_err = 1'b0;
        @(negedge clk);
        while (!cmd_ready && guard < 5000) begin @(negedge clk); guard++; end
        log_n = 0;
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_mask = m; cmd_retries = tr;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        guard = 0;
        while (dones == 0 && guard < 20000) begin
            if (rsp_done) begin dones++; got = rsp_data; got_err = rsp_err; end
            else begin @(negedge clk); guard++; end
        end
        if (guard >= 20000) chk(1'b0, "R10", "command never completed", 0, 1);
        repeat (3) begin @(negedge clk); if (rsp_done) dones++; end
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [17:0] addr;
        logic [31:0] data;
        logic [31:0] mask;
        logic [7:0]  tries;
        logic [31:0] exp;
        logic        exp_err;
        logic [7:0]  exp_n;
    } vec_t;

    // A: page 3 sub 2 reg 4; B: page 5 sub 0 reg 0.
    localparam logic [17:0] A = 18'h00688;
    localparam logic [17:0] B = 18'h00A00;
    localparam logic [17:0] P = 18'h00E44;

    localparam vec_t VECS [8] = '{
        '{2'd1, A, 32'hDEADBEEF, 32'h0,        8'd0, 32'hDEADBEEF, 1'b0, 8'd3},
        '{2'd0, A, 32'h0,        32'h0,        8'd0, 32'hDEADBEEF, 1'b0, 8'd2},
        '{2'd2, A, 32'h00001234, 32'h0000FFFF, 8'd0, 32'hDEAD1234, 1'b0, 8'd4},
        '{2'd0, A, 32'h0,        32'h0,        8'd0, 32'hDEAD1234, 1'b0, 8'd2},
        '{2'd1, B, 32'h01234567, 32'h0,        8'd0, 32'h01234567, 1'b0, 8'd3},
        '{2'd0, A, 32'h0,        32'h0,        8'd0, 32'hDEAD1234, 1'b0, 8'd3},
        '{2'd3, A, 32'hDEAD0000, 32'hFFFF0000, 8'd3, 32'hDEAD1234, 1'b0, 8'd2},
        '{2'd3, A, 32'h00000000, 32'hFFFFFFFF, 8'd2, 32'hDEAD1234, 1'b1, 8'd6}
    };

    function automatic string tag_of(logic [1:0] op, logic e);
        case (op)
            2'd0: return "R5";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return e ? "R9" : "R8";
        endcase
    endfunction

    // Global watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic        ge;
        int          dn;

        repeat (4) @(negedge clk);
        // R12: reset state.
        chk(cmd_ready === 1'b1, "R12", "cmd_ready in reset", 32'(cmd_ready), 1);
        chk(mdio_req === 1'b0,  "R12", "mdio_req in reset", 32'(mdio_req), 0);
        chk(rsp_done === 1'b0,  "R12", "rsp_done in reset", 32'(rsp_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready === 1'b1 && mdio_req === 1'b0, "R12", "idle after reset",
            32'({cmd_ready, mdio_req}), 32'b10);

        for (int i = 0; i < 8; i++) begin
            run_cmd(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].mask,
                    VECS[i].tries, got, ge, dn);
            chk(got === VECS[i].exp, tag_of(VECS[i].op, VECS[i].exp_err), "rsp_data",
                got, VECS[i].exp);
            chk(ge === VECS[i].exp_err, tag_of(VECS[i].op, VECS[i].exp_err), "rsp_err",
                32'(ge), 32'(VECS[i].exp_err));
            chk(log_n == int'(VECS[i].exp_n), tag_of(VECS[i].op, VECS[i].exp_err),
                "transaction count", log_n, 32'(VECS[i].exp_n));
            chk(dn == 1, "R10", "done pulses", dn, 1);
            if (i == 0) begin
                // R2: first access after reset writes the page register.
                chk(log_phy[0] == 5'h18 && log_reg[0] == 5'd0 && log_wr[0] &&
                    log_wd[0] == 16'd3, "R2", "page write", {log_phy[0], log_wd[0]},
                    {5'h18, 16'd3});
                // R3: settle delay before the first data request.
                chk(log_t[1] - log_t[0] >= LAT + SETTLE + 1, "R3", "settle gap",
                    log_t[1] - log_t[0], LAT + SETTLE + 1);
                // R6 and R1: low half first, PHY 0x12, registers 4 then 5.
                chk(log_phy[1] == 5'h12 && log_reg[1] == 5'd4 && log_wd[1] == 16'hBEEF,
                    "R6", "first half", {log_reg[1], log_wd[1]}, {5'd4, 16'hBEEF});
                chk(log_phy[2] == 5'h12 && log_reg[2] == 5'd5 && log_wd[2] == 16'hDEAD,
                    "R1", "second half", {log_phy[2], log_wd[2]}, {5'h12, 16'hDEAD});
            end
            if (i == 1) begin
                // R4: page hit goes straight to data, R5: low then high read.
                chk(log_phy[0] == 5'h12 && !log_wr[0] && log_reg[0] == 5'd4, "R4",
                    "no page write on hit", {log_phy[0], log_reg[0]}, {5'h12, 5'd4});
                chk(log_reg[1] == 5'd5 && !log_wr[1], "R5", "high half read second",
                    32'(log_reg[1]), 5);
            end
            if (i == 4)
                chk(log_wd[0] == 16'd5 && log_phy[1] == 5'h10, "R1", "page 5 sub 0",
                    {log_wd[0], log_phy[1]}, {16'd5, 5'h10});
        end

        // R6: high half first when cfg_lo_first is 0.
        cfg_lo_first = 1'b0;
        run_cmd(2'd1, A, 32'h11112222, 32'h0, 8'd0, got, ge, dn);
        cfg_lo_first = 1'b1;
        chk(log_n == 2 && log_reg[0] == 5'd5 && log_wd[0] == 16'h1111, "R6",
            "hi-first first write", {log_reg[0], log_wd[0]}, {5'd5, 16'h1111});
        chk(log_reg[1] == 5'd4 && log_wd[1] == 16'h2222, "R6", "hi-first second write",
            {log_reg[1], log_wd[1]}, {5'd4, 16'h2222});

        // R8: poll that matches on the third attempt, with retry gaps.
        poll_reads = 0; poll_need = 3;
        run_cmd(2'd3, P, 32'h1, 32'h1, 8'd10, got, ge, dn);
        chk(got === 32'h1 && ge === 1'b0, "R8", "late match result", {ge, got[30:0]}, 1);
        chk(log_n == 7, "R8", "attempts on late match", log_n, 7);
        chk(log_t[3] - log_t[2] >= LAT + GAP + 1, "R8", "retry gap",
            log_t[3] - log_t[2], LAT + GAP + 1);
        chk(dn == 1, "R10", "done pulses on poll", dn, 1);

        // R10 and R9: a command pulsed during a failing poll is ignored.
        poll_reads = 0; poll_need = 1000;
        fork
            run_cmd(2'd3, P, 32'h1, 32'h1, 8'd10, got, ge, dn);
            begin
                repeat (10) @(negedge clk);
                cmd_op = 2'd1; cmd_addr = A; cmd_wdata = 32'h55555555;
                cmd_valid = 1'b1;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        join
        chk(ge === 1'b1 && got === 32'h0, "R9", "poll timeout", {ge, got[30:0]}, 32'h80000000);
        chk(log_n == 22, "R9", "attempts before timeout", log_n, 22);
        run_cmd(2'd0, A, 32'h0, 32'h0, 8'd0, got, ge, dn);
        chk(got === 32'h11112222, "R10", "busy command ignored", got, 32'h11112222);

        // R11: request fields held until each acknowledge.
        chk(stab_err == 0, "R11", "field changes before ack", stab_err, 0);

        // R2: reset empties the page cache.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(cmd_ready === 1'b1 && rsp_done === 1'b0, "R12", "ready after second reset",
            32'({cmd_ready, rsp_done}), 32'b10);
        run_cmd(2'd0, A, 32'h0, 32'h0, 8'd0, got, ge, dn);
        chk(log_n == 3 && log_phy[0] == 5'h18, "R2", "page rewritten after reset",
            log_n, 3);
        chk(got === 32'h11112222, "R5", "read after reset", got, 32'h11112222);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule